// File: doc/BRIEF.md
# Half-Bias Multiplexed Segment LCD Sequencer

This block produces the pin patterns for a multiplexed segment LCD driven at half bias. Every common pin gets a two-bit level code each cycle: drive high, drive low, or connect to a shared mid-supply bias bus. Each segment pin gets a plain logic level. A frame walks through the enabled commons in order. Each common is active for one slot of `alpha` timer ticks at high polarity and then one slot at low polarity. While one common is active, the others rest on the bias bus. A dead time ends the frame, and during it every common and every segment sits at full supply. Widening the dead time narrows the slots, so contrast drops while the frame rate stays the same.

The surrounding chip supplies a timer tick, the number of commons in use, the requested slot width, the frame length in ticks and a pixel bitmap. The block clamps the slot width to a legal range. It latches all settings once per frame, so software may rewrite them at any time. The bias voltage and the analog switches sit outside the block.

Top module: `lcd_hb_driver`

## Requirements
- R1: After reset, and from the clock after `enable` is seen low, every common carries the bias code and every segment is 0. Ticks have no effect while `enable` is low.
- R2: A common code is 2'b00 for drive low, 2'b01 for drive high and 2'b10 for bias. Code 2'b11 never appears. Common c occupies `com_lvl[2c+1:2c]`.
- R3: The first tick with `enable` high starts a frame. Slots follow the order common 0 high, common 0 low, common 1 high, common 1 low, and so on up to the last enabled common. Each slot lasts the clamped alpha in ticks. During a slot only the active common leaves bias, so at most one common is off bias outside the dead time.
- R4: Pixel (c, s) is bit `c*SEGS+s` of `pixels`. In the high slot of common c, segment s is 0 when the pixel is lit and 1 when it is dark. In the low slot it is 1 when lit and 0 when dark.
- R5: After the last slot, all commons are high and all segments are 1 for the dead time. The dead time is `frame_len - 2*n*alpha` ticks, so each frame lasts exactly `frame_len` ticks. The tick that ends the dead time starts the next frame.
- R6: A requested alpha below `ALPHA_MIN` is used as `ALPHA_MIN`.
- R7: A requested alpha above floor((`frame_len` - `ALPHA_MIN`) / 2n) is used as that maximum. If that maximum is itself below `ALPHA_MIN`, alpha is `ALPHA_MIN` and the dead time is `ALPHA_MIN` ticks.
- R8: A common count below 2 is used as 2. A common count above `MAX_COMS` is used as `MAX_COMS`.
- R9: Alpha, frame length, common count and pixels are sampled on the tick that starts a frame. Changes during a frame take effect at the next frame start.
- R10: Dropping `enable` in the middle of a frame returns the block to idle on the next clock. The next tick with `enable` high starts a fresh frame at slot 0.
- R11: While `enable` is high, the outputs change only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the frame sequence; low forces idle |
| tick | input | 1 | Timer tick, one clock wide per tick |
| num_coms | input | $clog2(MAX_COMS+1) | Requested number of commons |
| alpha | input | TW | Requested slot width in ticks |
| frame_len | input | TW | Frame length in ticks |
| pixels | input | MAX_COMS*SEGS | Pixel bitmap, bit c*SEGS+s |
| com_lvl | output | 2*MAX_COMS | Level code per common |
| seg_out | output | SEGS | Segment levels |

## Verification
The directed frames target each clamp edge. One frame has alpha under the floor, one has alpha above the frame-derived ceiling, and one has a frame too short to hold the minimum. A design that clamped in the wrong order, or that let the dead time underflow, would produce a frame of the wrong length or a dead phase that never ends. Common counts of 0 and 7 check the count clamp, which would otherwise index commons that do not exist. Every frame rewrites all settings after its first slot, so a design without shadow registers would stretch or reorder the slots in flight. Dropping `enable` mid-frame catches a sequencer that resumes from where it stopped instead of from slot 0.

// File: rtl/lcd_hb_pkg.sv
package lcd_hb_pkg;
   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_HIGH = 2'b01,
      LVL_BIAS = 2'b10
   } lvl_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_ACT  = 2'b01,
      PH_DEAD = 2'b10
   } phase_e;
endpackage

// File: rtl/lcd_hb_clamp.sv
// Legalises the frame settings: common count, slot width and dead time.
module lcd_hb_clamp #(
   parameter int MAX_COMS  = 4,
   parameter int TW        = 16,
   parameter int ALPHA_MIN = 8,
   localparam int CW       = $clog2(MAX_COMS + 1)
) (
   input  logic [CW-1:0] num_coms,
   input  logic [TW-1:0] alpha,
   input  logic [TW-1:0] frame_len,
   output logic [CW-1:0] n_eff,
   output logic [TW-1:0] alpha_eff,
   output logic [TW-1:0] dead_len
);
   localparam logic [TW-1:0] AMIN = TW'(ALPHA_MIN);

   logic [TW-1:0] span, two_n, amax, prod;
   logic          too_short;

   always_comb begin
      if (num_coms < CW'(2))
         n_eff = CW'(2);
      else if (num_coms > CW'(MAX_COMS))
         n_eff = CW'(MAX_COMS);
      else
         n_eff = num_coms;
   end

   assign two_n     = TW'({n_eff, 1'b0});
   assign span      = (frame_len > AMIN) ? (frame_len - AMIN) : '0;
   assign amax      = span / two_n;
   assign too_short = (amax < AMIN);

   always_comb begin
      alpha_eff = (alpha > amax) ? amax : alpha;
      if (alpha_eff < AMIN)
         alpha_eff = AMIN;
   end

   assign prod     = alpha_eff * two_n;
   assign dead_len = too_short ? AMIN : (frame_len - prod);
endmodule

// File: rtl/lcd_hb_seq.sv
// Frame position tracker: phase, active common, polarity and tick counter.
module lcd_hb_seq
   import lcd_hb_pkg::*;
#(
   parameter int MAX_COMS = 4,
   parameter int TW       = 16,
   localparam int CW      = $clog2(MAX_COMS + 1),
   localparam int CIW     = (MAX_COMS > 1) ? $clog2(MAX_COMS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enable,
   input  logic           tick,
   input  logic [CW-1:0]  n_eff,
   input  logic [TW-1:0]  alpha_eff,
   input  logic [TW-1:0]  dead_len,
   output phase_e         phase,
   output logic [CIW-1:0] cidx,
   output logic           pol_low,
   output logic           load
);
   phase_e         phase_q;
   logic [CIW-1:0] cidx_q;
   logic           pol_q;
   logic [TW-1:0]  cnt_q, alpha_q, dead_q;
   logic [CW-1:0]  n_q;
   logic           slot_end, dead_end, last_com;

   assign slot_end = (cnt_q == alpha_q - 1'b1);
   assign dead_end = (cnt_q == dead_q - 1'b1);
   assign last_com = (CW'(cidx_q) + 1'b1 == n_q);
   assign load     = enable && tick &&
                     ((phase_q == PH_IDLE) || ((phase_q == PH_DEAD) && dead_end));

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         phase_q <= PH_IDLE;
         cidx_q  <= '0;
         pol_q   <= 1'b0;
         cnt_q   <= '0;
         if (!rst_n) begin
            alpha_q <= '0;
            dead_q  <= '0;
            n_q     <= '0;
         end
      end else if (load) begin
         phase_q <= PH_ACT;
         cidx_q  <= '0;
         pol_q   <= 1'b0;
         cnt_q   <= '0;
         alpha_q <= alpha_eff;
         dead_q  <= dead_len;
         n_q     <= n_eff;
      end else if (tick) begin
         case (phase_q)
            PH_ACT: begin
               if (slot_end) begin
                  cnt_q <= '0;
                  if (!pol_q) begin
                     pol_q <= 1'b1;
                  end else begin
                     pol_q <= 1'b0;
                     if (last_com)
                        phase_q <= PH_DEAD;
                     else
                        cidx_q <= cidx_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DEAD: cnt_q <= cnt_q + 1'b1;
            default: cnt_q <= '0;
         endcase
      end
   end

   assign phase   = phase_q;
   assign cidx    = cidx_q;
   assign pol_low = pol_q;
endmodule

// File: rtl/lcd_hb_pins.sv
// Turns the frame position and latched pixels into pin codes.
module lcd_hb_pins
   import lcd_hb_pkg::*;
#(
   parameter int MAX_COMS = 4,
   parameter int SEGS     = 8,
   localparam int CIW     = (MAX_COMS > 1) ? $clog2(MAX_COMS) : 1
) (
   input  phase_e                     phase,
   input  logic [CIW-1:0]             cidx,
   input  logic                       pol_low,
   input  logic [MAX_COMS*SEGS-1:0]   pix_sh,
   output logic [2*MAX_COMS-1:0]      com_lvl,
   output logic [SEGS-1:0]            seg_out
);
   logic [SEGS-1:0] row;
   assign row = pix_sh[cidx*SEGS +: SEGS];

   for (genvar c = 0; c < MAX_COMS; c++) begin : g_com
      lvl_e lvl;
      always_comb begin
         case (phase)
            PH_DEAD: lvl = LVL_HIGH;
            PH_ACT:  lvl = (cidx == CIW'(c)) ? (pol_low ? LVL_LOW : LVL_HIGH) : LVL_BIAS;
            default: lvl = LVL_BIAS;
         endcase
      end
      assign com_lvl[2*c +: 2] = lvl;
   end

   always_comb begin
      case (phase)
         PH_DEAD: seg_out = '1;
         PH_ACT:  seg_out = pol_low ? row : ~row;
         default: seg_out = '0;
      endcase
   end
endmodule

// File: rtl/lcd_hb_driver.sv
module lcd_hb_driver
   import lcd_hb_pkg::*;
#(
   parameter int MAX_COMS  = 4,
   parameter int SEGS      = 8,
   parameter int TW        = 16,
   parameter int ALPHA_MIN = 8,
   localparam int CW       = $clog2(MAX_COMS + 1),
   localparam int CIW      = (MAX_COMS > 1) ? $clog2(MAX_COMS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     tick,
   input  logic [CW-1:0]            num_coms,
   input  logic [TW-1:0]            alpha,
   input  logic [TW-1:0]            frame_len,
   input  logic [MAX_COMS*SEGS-1:0] pixels,
   output logic [2*MAX_COMS-1:0]    com_lvl,
   output logic [SEGS-1:0]          seg_out
);
   if (MAX_COMS < 2 || MAX_COMS > 16) begin : g_bad_coms
      $error("lcd_hb_driver: MAX_COMS must be 2..16");
   end
   if (SEGS < 1) begin : g_bad_segs
      $error("lcd_hb_driver: SEGS must be at least 1");
   end
   if (ALPHA_MIN < 1 || ALPHA_MIN >= (1 << (TW - 1))) begin : g_bad_amin
      $error("lcd_hb_driver: ALPHA_MIN out of range for TW");
   end

   logic [CW-1:0]            n_eff;
   logic [TW-1:0]            alpha_eff, dead_len;
   phase_e                   phase;
   logic [CIW-1:0]           cidx;
   logic                     pol_low, load;
   logic [MAX_COMS*SEGS-1:0] pix_sh;

   lcd_hb_clamp #(.MAX_COMS(MAX_COMS), .TW(TW), .ALPHA_MIN(ALPHA_MIN)) u_clamp (
      .num_coms  (num_coms),
      .alpha     (alpha),
      .frame_len (frame_len),
      .n_eff     (n_eff),
      .alpha_eff (alpha_eff),
      .dead_len  (dead_len)
   );

   lcd_hb_seq #(.MAX_COMS(MAX_COMS), .TW(TW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tick      (tick),
      .n_eff     (n_eff),
      .alpha_eff (alpha_eff),
      .dead_len  (dead_len),
      .phase     (phase),
      .cidx      (cidx),
      .pol_low   (pol_low),
      .load      (load)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         pix_sh <= '0;
      else if (load)
         pix_sh <= pixels;
   end

   lcd_hb_pins #(.MAX_COMS(MAX_COMS), .SEGS(SEGS)) u_pins (
      .phase   (phase),
      .cidx    (cidx),
      .pol_low (pol_low),
      .pix_sh  (pix_sh),
      .com_lvl (com_lvl),
      .seg_out (seg_out)
   );
endmodule

// File: rtl/lcd_hb_driver_chk.sv
module lcd_hb_driver_chk #(
   parameter int MAX_COMS = 4,
   parameter int SEGS     = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  enable,
   input logic                  tick,
   input logic [2*MAX_COMS-1:0] com_lvl,
   input logic [SEGS-1:0]       seg_out
);
   int hi_cnt, nb_cnt;

   always_comb begin
      hi_cnt = 0;
      nb_cnt = 0;
      for (int c = 0; c < MAX_COMS; c++) begin
         if (com_lvl[2*c +: 2] == 2'b01) hi_cnt++;
         if (com_lvl[2*c +: 2] != 2'b10) nb_cnt++;
      end
   end

   for (genvar c = 0; c < MAX_COMS; c++) begin : g_code
      assert_no_code11_R2: assert property (@(posedge clk) disable iff (!rst_n)
         com_lvl[2*c +: 2] != 2'b11);
   end

   assert_idle_bias_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (com_lvl == {MAX_COMS{2'b10}}) && (seg_out == '0));

   assert_single_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt != MAX_COMS) |-> (nb_cnt <= 1));

   assert_dead_segs_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt == MAX_COMS) |-> (seg_out == '1));

   assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !tick) |=> ($stable(com_lvl) && $stable(seg_out)));
endmodule

bind lcd_hb_driver lcd_hb_driver_chk #(.MAX_COMS(MAX_COMS), .SEGS(SEGS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .enable  (enable),
   .tick    (tick),
   .com_lvl (com_lvl),
   .seg_out (seg_out)
);

// File: tb/lcd_hb_driver_test.sv
`timescale 1ns/1ps
module lcd_hb_driver_test;
   localparam int NC = 4, NS = 8, TW = 16, AMIN = 8;

   logic              clk = 1'b0;
   logic              rst_n, enable, tick;
   logic [2:0]        num_coms;
   logic [TW-1:0]     alpha, frame_len;
   logic [NC*NS-1:0]  pixels;
   logic [2*NC-1:0]   com_lvl;
   logic [NS-1:0]     seg_out;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   lcd_hb_driver #(.MAX_COMS(NC), .SEGS(NS), .TW(TW), .ALPHA_MIN(AMIN)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .num_coms(num_coms),
      .alpha(alpha), .frame_len(frame_len), .pixels(pixels),
      .com_lvl(com_lvl), .seg_out(seg_out));

   function automatic int eff_n(int raw);
      return (raw < 2) ? 2 : ((raw > NC) ? NC : raw);
   endfunction
   function automatic int amax_of(int f, int n);
      return ((f > AMIN) ? f - AMIN : 0) / (2 * n);
   endfunction
   function automatic int eff_alpha(int a, int f, int n);
      int r = (a > amax_of(f, n)) ? amax_of(f, n) : a;
      return (r < AMIN) ? AMIN : r;
   endfunction
   function automatic int eff_dead(int a, int f, int n);
      if (amax_of(f, n) < AMIN) return AMIN;
      return f - 2 * n * eff_alpha(a, f, n);
   endfunction
   function automatic logic [2*NC-1:0] com_word(int c, bit hi);
      logic [2*NC-1:0] w;
      for (int i = 0; i < NC; i++) w[2*i +: 2] = (i == c) ? (hi ? 2'b01 : 2'b00) : 2'b10;
      return w;
   endfunction

   task automatic check_out(string req, logic [2*NC-1:0] ec, logic [NS-1:0] es);
      checks++;
      if (com_lvl !== ec || seg_out !== es) begin
         errors++;
         $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h", req, com_lvl, seg_out, ec, es);
      end
   endtask

   task automatic drive(int n, int a, int f, logic [NC*NS-1:0] p);
      num_coms = 3'(n); alpha = TW'(a); frame_len = TW'(f); pixels = p;
   endtask

   task automatic tick_once();
      int gap = $urandom % 3;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
   endtask

   // Checks one whole frame from slot 0; drives junk settings after the first
   // slot (R9) and the next frame's settings before the final tick.
   task automatic run_frame(int nr, int a, int f, logic [NC*NS-1:0] p,
                            int nn, int na, int nf, logic [NC*NS-1:0] np, string tag);
      int n = eff_n(nr);
      int ae = eff_alpha(a, f, n);
      int de = eff_dead(a, f, n);
      for (int k = 0; k < 2 * n; k++) begin
         for (int t = 0; t < ae; t++) begin
            logic [NS-1:0] row = p[(k/2)*NS +: NS];
            check_out({tag, " R3 R4 R9 slot"}, com_word(k / 2, (k % 2) == 0),
                      ((k % 2) == 0) ? ~row : row);
            if (k == 1 && t == 0)
               drive($urandom % 8, $urandom % 60, 20 + $urandom % 150,
                     {$urandom, $urandom});
            tick_once();
         end
      end
      for (int t = 0; t < de; t++) begin
         check_out({tag, " R5 dead"}, {NC{2'b01}}, '1);
         if (t == de - 1) drive(nn, na, nf, np);
         tick_once();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int dn[7] = '{2, 3, 4, 2, 0, 7, 3};
      int da[7] = '{10, 3, 50, 20, 9, 9, 12};
      int df[7] = '{100, 90, 120, 30, 80, 100, 110};
      string dt[7] = '{"R3", "R6", "R7 max", "R7 short", "R8 low", "R8 high", "R4"};
      logic [NC*NS-1:0] cp, np;
      int cn, ca, cf, nn, na, nf;

      rst_n = 1'b0; enable = 1'b0; tick = 1'b0;
      drive(2, 10, 100, '0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check_out("R1 reset", {NC{2'b10}}, '0);
      tick_once();
      check_out("R1 tick while disabled", {NC{2'b10}}, '0);
      enable = 1'b1;
      repeat (3) begin @(posedge clk); #1; end
      check_out("R11 enabled without tick", {NC{2'b10}}, '0);

      cn = dn[0]; ca = da[0]; cf = df[0]; cp = {$urandom, $urandom};
      drive(cn, ca, cf, cp);
      tick_once();
      for (int i = 0; i < 12; i++) begin
         string tg = (i < 7) ? dt[i] : "R9 random";
         if (i + 1 < 7) begin
            nn = dn[i+1]; na = da[i+1]; nf = df[i+1];
         end else begin
            nn = $urandom % 8; na = $urandom % 40; nf = 20 + $urandom % 180;
         end
         np = {$urandom, $urandom};
         if (i == 6) np = {NS{4'b1010}};
         run_frame(cn, ca, cf, cp, nn, na, nf, np, tg);
         cn = nn; ca = na; cf = nf; cp = np;
      end

      // R10: abort mid-frame, then restart from slot 0
      tick_once();
      enable = 1'b0;
      @(posedge clk); #1;
      check_out("R10 abort to idle", {NC{2'b10}}, '0);
      tick_once();
      check_out("R1 idle ignores tick", {NC{2'b10}}, '0);
      enable = 1'b1;
      cn = 3; ca = 9; cf = 95; cp = {$urandom, $urandom};
      drive(cn, ca, cf, cp);
      tick_once();
      run_frame(cn, ca, cf, cp, 2, 8, 60, '1, "R10 restart");
      check_out("R4 all lit slot0", com_word(0, 1'b1), '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule